// File: doc/BRIEF.md
# ADC Code to Temperature Interpolator

This block turns a raw reading from an on-die temperature sensor into a signed temperature in millidegrees Celsius. It holds a fixed calibration curve as a small constant ROM. The curve has one point every 5 °C from -40 °C to 125 °C, and the code falls as the temperature rises. Two sentinel points sit beyond the ends so that every code has a bracketing pair of entries.

A request is one `start` pulse carrying the code. The block then walks a binary search over the ROM to find the pair of entries whose codes enclose the input. It forms the interpolation numerator with one multiply and divides it by the code span of that pair. The divider is a restoring divider that produces one quotient bit per cycle. The result appears on a registered output, qualified by a one-cycle `res_valid` pulse. Input codes wider than the 12-bit sensor range are rejected with an error flag and take no search.

Top module: `thermcode_interp`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `res_valid`, `res_err` and `busy` are 0 and `res_temp` is 0.
- R2: A code equal to a calibration point returns that point's temperature exactly. For example, 3728 gives 0 and 3437 gives 120000.
- R3: Between calibration points the result is T(i-1) + (T(i)-T(i-1))·(code(i-1)-x)/(code(i-1)-code(i)). The division truncates, and entry i is chosen so that code(i) ≤ x < code(i-1). For example, 3700 gives 14000, 3745 gives -9000 and 3604 gives 58181.
- R4: Every code from 3800 up to 4095 gives -40000.
- R5: Every code from 0 up to 3421 gives 125000.
- R6: An input above 4095, accepted while idle, gives `res_valid` together with `res_err`=1 and `res_temp`=0 on the next clock edge.
- R7: `busy` rises on the edge that accepts `start` and falls on the edge after the `res_valid` cycle. `res_valid` is high for exactly one cycle and only while `busy` is high.
- R8: A `start` that arrives while `busy` is high is ignored. It produces no result and does not change the result in flight.
- R9: A result follows an accepted `start` within 36 cycles with the default parameters.
- R10: `res_temp` and `res_err` hold their values in every cycle in which `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse; sampled only while idle |
| code_in | input | IN_W (16) | Sensor code; values above 4095 are invalid |
| busy | output | 1 | High from acceptance until the result cycle ends |
| res_valid | output | 1 | One-cycle result strobe |
| res_err | output | 1 | Result is an invalid-code error |
| res_temp | output | TEMP_W (32) | Signed temperature in millidegrees |

## Verification
A search that lands on the wrong bracket shows up as a temperature that is off by one or more 5000-millidegree steps. This appears on the first `res_valid` pulse after the offending request. A broken divider step corrupts only the interpolated fraction, so it can only be seen with codes that do not sit on a calibration point. The bench therefore sweeps the whole code range at a fine stride. A control state that fails to return to idle shows up as a missing strobe within the latency bound, or as a second strobe with no request behind it. A start that leaks in while busy shows up as an unexpected result at the scoreboard.

// File: rtl/thermcode_pkg.sv
package thermcode_pkg;

  localparam int CODE_W   = 12;
  localparam int TBL_N    = 36;
  localparam int TBL_AW   = $clog2(TBL_N);
  localparam int STEP_MC  = 5000;
  localparam int COLD_MC  = -40000;
  localparam int HOT_MC   = 125000;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEARCH,
    ST_MUL,
    ST_DIV,
    ST_DONE
  } tc_state_t;

  // Calibration codes, descending; index 0 and TBL_N-1 are saturation sentinels.
  function automatic logic [CODE_W-1:0] tbl_code(input int idx);
    case (idx)
      0:  return 12'd4095;
      1:  return 12'd3800;
      2:  return 12'd3792;
      3:  return 12'd3783;
      4:  return 12'd3774;
      5:  return 12'd3765;
      6:  return 12'd3756;
      7:  return 12'd3747;
      8:  return 12'd3737;
      9:  return 12'd3728;
      10: return 12'd3718;
      11: return 12'd3708;
      12: return 12'd3698;
      13: return 12'd3688;
      14: return 12'd3678;
      15: return 12'd3667;
      16: return 12'd3656;
      17: return 12'd3645;
      18: return 12'd3634;
      19: return 12'd3623;
      20: return 12'd3611;
      21: return 12'd3600;
      22: return 12'd3588;
      23: return 12'd3575;
      24: return 12'd3563;
      25: return 12'd3550;
      26: return 12'd3537;
      27: return 12'd3524;
      28: return 12'd3510;
      29: return 12'd3496;
      30: return 12'd3482;
      31: return 12'd3467;
      32: return 12'd3452;
      33: return 12'd3437;
      34: return 12'd3421;
      default: return 12'd0;
    endcase
  endfunction

  // Temperatures are computed from the fixed step rather than stored.
  function automatic logic signed [31:0] tbl_temp(input int idx);
    if (idx <= 0)
      return 32'(COLD_MC);
    else if (idx >= TBL_N - 1)
      return 32'(HOT_MC);
    else
      return 32'(COLD_MC + (idx - 1) * STEP_MC);
  endfunction

endpackage

// File: rtl/thermcode_rom.sv
module thermcode_rom
  import thermcode_pkg::*;
#(
  parameter int TEMP_W = 32
) (
  input  logic [TBL_AW-1:0]        addr,
  output logic [CODE_W-1:0]        code_cur,
  output logic [CODE_W-1:0]        code_prev,
  output logic signed [TEMP_W-1:0] temp_cur,
  output logic signed [TEMP_W-1:0] temp_prev
);

  localparam int PORTS = 2;

  logic [TBL_AW-1:0]        port_addr [PORTS];
  logic [CODE_W-1:0]        port_code [PORTS];
  logic signed [TEMP_W-1:0] port_temp [PORTS];

  // Port 0 reads the entry itself, port 1 the warmer-code neighbour above it.
  assign port_addr[0] = addr;
  assign port_addr[1] = (addr == '0) ? '0 : TBL_AW'(addr - 1'b1);

  generate
    for (genvar p = 0; p < PORTS; p++) begin : g_port
      assign port_code[p] = tbl_code(int'(port_addr[p]));
      assign port_temp[p] = TEMP_W'(tbl_temp(int'(port_addr[p])));
    end
  endgenerate

  assign code_cur  = port_code[0];
  assign code_prev = port_code[1];
  assign temp_cur  = port_temp[0];
  assign temp_prev = port_temp[1];

endmodule

// File: rtl/thermcode_search.sv
module thermcode_search
  import thermcode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              active_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [CODE_W-1:0] c_mid_i,
  input  logic [CODE_W-1:0] c_prev_i,
  output logic [TBL_AW-1:0] mid_o,
  output logic              hit_o,
  output logic [TBL_AW-1:0] idx_o
);

  localparam int W = TBL_AW + 1;

  logic [W-1:0] lo_q, hi_q, mid;
  logic         empty, bracket;

  assign mid     = W'((lo_q + hi_q) >> 1);
  assign empty   = (lo_q > hi_q) || (mid == '0);
  assign bracket = (code_i >= c_mid_i) && (code_i < c_prev_i);
  assign hit_o   = active_i && (empty || bracket);
  // Only the top code of the range misses every bracket; entry 1 then yields the cold limit.
  assign idx_o   = empty ? TBL_AW'(1) : mid[TBL_AW-1:0];
  assign mid_o   = mid[TBL_AW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (load_i) begin
      lo_q <= '0;
      hi_q <= W'(TBL_N - 1);
    end else if (active_i && !hit_o) begin
      if (code_i < c_mid_i)
        lo_q <= W'(mid + 1'b1);
      else
        hi_q <= W'(mid - 1'b1);
    end
  end

endmodule

// File: rtl/thermcode_divider.sv
module thermcode_divider #(
  parameter int NUM_W = 20,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quot_o
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] shift_q;
  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [CNT_W-1:0] cnt_q;
  logic [DEN_W:0]   trial;
  logic             fits;

  assign trial = {rem_q, shift_q[NUM_W-1]};
  assign fits  = (trial >= {1'b0, den_q});

  always_ff @(posedge clk) begin
    if (rst) begin
      shift_q <= '0;
      rem_q   <= '0;
      den_q   <= '0;
      cnt_q   <= '0;
      quot_o  <= '0;
      done_o  <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        shift_q <= num_i;
        rem_q   <= '0;
        den_q   <= den_i;
        quot_o  <= '0;
        cnt_q   <= CNT_W'(NUM_W);
      end else if (cnt_q != '0) begin
        shift_q <= {shift_q[NUM_W-2:0], 1'b0};
        rem_q   <= fits ? DEN_W'(trial - {1'b0, den_q}) : trial[DEN_W-1:0];
        quot_o  <= {quot_o[NUM_W-2:0], fits};
        cnt_q   <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1))
          done_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/thermcode_interp.sv
module thermcode_interp
  import thermcode_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int TEMP_W = 32,
  parameter int NUM_W  = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [IN_W-1:0]          code_in,
  output logic                     busy,
  output logic                     res_valid,
  output logic                     res_err,
  output logic signed [TEMP_W-1:0] res_temp
);

  localparam logic [IN_W-1:0] CODE_MAX = IN_W'({CODE_W{1'b1}});

  tc_state_t                state_q;
  logic [CODE_W-1:0]        code_q;
  logic [TBL_AW-1:0]        idx_q;
  logic signed [TEMP_W-1:0] base_q;

  logic [TBL_AW-1:0]        rom_addr, mid, hit_idx;
  logic [CODE_W-1:0]        c_cur, c_prev;
  logic signed [TEMP_W-1:0] t_cur, t_prev;
  logic                     hit, load, div_start, div_done;
  logic [NUM_W-1:0]         num, quot;
  logic [CODE_W-1:0]        den;

  assign busy      = (state_q != ST_IDLE);
  assign load      = (state_q == ST_IDLE) && start && (code_in <= CODE_MAX);
  assign div_start = (state_q == ST_MUL);
  assign rom_addr  = (state_q == ST_SEARCH) ? mid : idx_q;

  // Step is 0 on sentinel spans and the code gap is small elsewhere, so NUM_W bits suffice.
  assign num = NUM_W'(t_cur - t_prev) * NUM_W'(c_prev - code_q);
  assign den = c_prev - c_cur;

  thermcode_rom #(.TEMP_W(TEMP_W)) u_rom (
    .addr      (rom_addr),
    .code_cur  (c_cur),
    .code_prev (c_prev),
    .temp_cur  (t_cur),
    .temp_prev (t_prev)
  );

  thermcode_search u_search (
    .clk      (clk),
    .rst      (rst),
    .load_i   (load),
    .active_i (state_q == ST_SEARCH),
    .code_i   (code_q),
    .c_mid_i  (c_cur),
    .c_prev_i (c_prev),
    .mid_o    (mid),
    .hit_o    (hit),
    .idx_o    (hit_idx)
  );

  thermcode_divider #(.NUM_W(NUM_W), .DEN_W(CODE_W)) u_div (
    .clk     (clk),
    .rst     (rst),
    .start_i (div_start),
    .num_i   (num),
    .den_i   (den),
    .done_o  (div_done),
    .quot_o  (quot)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      code_q    <= '0;
      idx_q     <= '0;
      base_q    <= '0;
      res_valid <= 1'b0;
      res_err   <= 1'b0;
      res_temp  <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (start) begin
            if (code_in > CODE_MAX) begin
              res_err   <= 1'b1;
              res_temp  <= '0;
              res_valid <= 1'b1;
              state_q   <= ST_DONE;
            end else begin
              code_q  <= code_in[CODE_W-1:0];
              state_q <= ST_SEARCH;
            end
          end
        end
        ST_SEARCH: begin
          if (hit) begin
            idx_q   <= hit_idx;
            state_q <= ST_MUL;
          end
        end
        ST_MUL: begin
          base_q  <= t_prev;
          state_q <= ST_DIV;
        end
        ST_DIV: begin
          if (div_done) begin
            res_temp  <= base_q + $signed({{(TEMP_W-NUM_W){1'b0}}, quot});
            res_err   <= 1'b0;
            res_valid <= 1'b1;
            state_q   <= ST_DONE;
          end
        end
        ST_DONE: begin
          res_valid <= 1'b0;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/thermcode_interp_chk.sv
module thermcode_interp_chk #(
  parameter int IN_W    = 16,
  parameter int TEMP_W  = 32,
  parameter int LAT_MAX = 36
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     start,
  input logic [IN_W-1:0]          code_in,
  input logic                     busy,
  input logic                     res_valid,
  input logic                     res_err,
  input logic signed [TEMP_W-1:0] res_temp
);

  localparam logic [IN_W-1:0] CODE_MAX = IN_W'(4095);

  logic rst_seen;
  int   busy_run;

  always_ff @(posedge clk) begin
    rst_seen <= rst;
    if (rst_seen === 1'b1) begin
      p_reset_clear_r1: assert (!res_valid && !busy && !res_err && res_temp == '0)
        else $error("R1 outputs not clear after reset");
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !busy) busy_run <= 0;
    else              busy_run <= busy_run + 1;
  end

  p_latency_r9: assert property (@(posedge clk) disable iff (rst)
    busy_run < LAT_MAX);

  p_err_path_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && code_in > CODE_MAX) |=> (res_valid && res_err && res_temp == '0));

  p_accept_busy_r7: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_valid_single_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  p_valid_in_busy_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> busy);

  p_busy_end_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(res_valid));

  p_idle_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> !busy);

  p_hold_r10: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> ($stable(res_temp) && $stable(res_err)));

  p_range_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_err) |-> (res_temp >= -40000 && res_temp <= 125000));

endmodule

bind thermcode_interp thermcode_interp_chk #(
  .IN_W    (IN_W),
  .TEMP_W  (TEMP_W),
  .LAT_MAX (2 * thermcode_pkg::TBL_AW + NUM_W + 4)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .code_in   (code_in),
  .busy      (busy),
  .res_valid (res_valid),
  .res_err   (res_err),
  .res_temp  (res_temp)
);

// File: tb/sim_thermcode_interp.sv
`timescale 1ns/1ps
module sim_thermcode_interp;

  localparam int IN_W   = 16;
  localparam int TEMP_W = 32;
  localparam int LAT    = 36;
  localparam int WDOG   = 190000;

  typedef struct {
    logic  err;
    int    temp;
    int    code;
    string tag;
  } exp_t;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic                     start = 1'b0;
  logic [IN_W-1:0]          code_in = '0;
  logic                     busy, res_valid, res_err;
  logic signed [TEMP_W-1:0] res_temp;

  int   n_checks = 0;
  int   n_errors = 0;
  exp_t exp_q[$];
  int   bc [36];
  int   bt [36];
  logic prev_valid = 1'b0;
  int   last_temp  = 0;
  logic last_err   = 1'b0;

  always #4 clk = ~clk;

  thermcode_interp #(.IN_W(IN_W), .TEMP_W(TEMP_W)) u0 (
    .clk(clk), .rst(rst), .start(start), .code_in(code_in),
    .busy(busy), .res_valid(res_valid), .res_err(res_err), .res_temp(res_temp)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic int model(input int c);
    for (int i = 1; i < 36; i++)
      if (bc[i] <= c && c < bc[i-1])
        return bt[i-1] + ((bt[i] - bt[i-1]) * (bc[i-1] - c)) / (bc[i-1] - bc[i]);
    return -40000;
  endfunction

  // Scoreboard monitor: every strobe must match the oldest outstanding request.
  always @(negedge clk) begin
    if (!rst) begin
      if (res_valid) begin
        check(!prev_valid, "R7 strobe longer than one cycle", 1, 0);
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 result without accepted request", int'(res_temp), 0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          check(res_err == e.err, {e.tag, " error flag"}, int'(res_err), int'(e.err));
          check(int'(res_temp) == e.temp, {e.tag, " temperature"}, int'(res_temp), e.temp);
        end
        last_temp = int'(res_temp);
        last_err  = res_err;
      end
      prev_valid = res_valid;
    end
  end

  task automatic wait_result();
    int n = 0;
    while (exp_q.size() != 0 && n < LAT + 2) begin
      @(negedge clk);
      n++;
    end
    if (exp_q.size() != 0) begin
      check(1'b0, "R9 result latency", n, LAT);
      exp_q.delete();
    end
  endtask

  task automatic send_exp(input int c, input logic err, input int t, input string tag,
                          input int noise);
    exp_t e;
    @(negedge clk);
    while (busy) @(negedge clk);
    start   = 1'b1;
    code_in = IN_W'(c);
    e.err = err; e.temp = t; e.code = c; e.tag = tag;
    exp_q.push_back(e);
    @(negedge clk);
    check(busy == 1'b1, "R7 busy after accepted start", int'(busy), 1);
    // R8: keep requesting while busy; none of these may be taken
    for (int k = 0; k < noise; k++) begin
      start   = 1'b1;
      code_in = (k % 2 == 0) ? 16'h2000 : 16'h0000;
      @(negedge clk);
    end
    start = 1'b0;
    wait_result();
  endtask

  task automatic send(input int c, input string tag);
    send_exp(c, 1'b0, model(c), tag, 0);
  endtask

  initial begin
    int tbl [36] = '{4095, 3800, 3792, 3783, 3774, 3765, 3756, 3747, 3737, 3728,
                     3718, 3708, 3698, 3688, 3678, 3667, 3656, 3645, 3634, 3623,
                     3611, 3600, 3588, 3575, 3563, 3550, 3537, 3524, 3510, 3496,
                     3482, 3467, 3452, 3437, 3421, 0};
    for (int i = 0; i < 36; i++) begin
      bc[i] = tbl[i];
      bt[i] = (i == 0) ? -40000 : (i == 35) ? 125000 : -40000 + (i - 1) * 5000;
    end
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_errors++;
    $display("FAIL watchdog: actual %0d cycles expected fewer", WDOG);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    check(!res_valid && !busy && !res_err, "R1 flags during reset", int'(busy), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!res_valid && !busy && !res_err, "R1 flags after reset", int'(res_valid), 0);
    check(res_temp == 0, "R1 temperature after reset", int'(res_temp), 0);

    // R2 exact calibration points
    send_exp(3728, 1'b0, 0, "R2 code 3728", 0);
    send_exp(3437, 1'b0, 120000, "R2 code 3437", 0);
    // R3 interpolation with truncation
    send_exp(3700, 1'b0, 14000, "R3 code 3700", 0);
    send_exp(3745, 1'b0, -9000, "R3 code 3745", 0);
    send_exp(3604, 1'b0, 58181, "R3 code 3604", 0);
    // R4 and R5 limits
    send_exp(4095, 1'b0, -40000, "R4 code 4095", 0);
    send_exp(3800, 1'b0, -40000, "R4 code 3800", 0);
    send_exp(3421, 1'b0, 125000, "R5 code 3421", 0);
    send_exp(0, 1'b0, 125000, "R5 code 0", 0);
    send_exp(3420, 1'b0, 125000, "R5 code 3420", 0);
    // R6 invalid inputs
    send_exp(4096, 1'b1, 0, "R6 code 0x1000", 0);
    send_exp(65535, 1'b1, 0, "R6 code 0xFFFF", 0);
    send_exp(3667, 1'b0, 30000, "R6 recovery after error", 0);
    // R8 requests while busy are dropped
    send_exp(3650, 1'b0, model(3650), "R8 noisy start", 6);
    send_exp(3510, 1'b0, 95000, "R8 noisy start", 3);

    // R10: result holds while no strobe
    repeat (12) @(negedge clk);
    check(!res_valid && int'(res_temp) == last_temp && res_err == last_err,
          "R10 hold", int'(res_temp), last_temp);

    // Sweep of the whole code range
    for (int c = 0; c < 4096; c += 3) begin
      if (c >= 3800)      send(c, "R4 sweep");
      else if (c <= 3421) send(c, "R5 sweep");
      else                send(c, "R3 sweep");
    end

    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R8 outstanding results", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule